// File: doc/BRIEF.md
# ATM Transmit Cell Scheduler with Idle Fill

This block sits between a cell-oriented input port and the transmit side of one T1/E1 link running a plain (non-grouped) user-network interface. Incoming 53-byte cells arrive one byte per cycle. They are written into a small cell buffer and only become visible to the output side once the whole cell has arrived. The output side delivers bytes one at a time, each in answer to a byte-request strobe from the downstream framer. The result is an unbroken run of whole cells.

At every cell boundary the scheduler decides what to send. If the link is enabled and the buffer holds a finished cell, it sends the oldest user cell. Otherwise it sends a fixed idle cell whose bytes it computes itself. As an option, cells that arrive already carrying an idle or unassigned header can be discarded on input so they never take buffer space. Software sets the usable buffer depth in cells. It can read the fill level to confirm that the buffer has drained before it reconfigures the link. A sticky flag reports any cell that was lost because the buffer was full.

Top module: `atm_tx_cell_sched`

## Requirements
- R1: At each cell boundary, if `link_en` is 1 and at least one complete cell is buffered, the next cell sent is the oldest buffered user cell, with all 53 bytes unchanged; otherwise an idle cell is sent.
- R2: An idle cell starts with header bytes 0x00, 0x00, 0x00, 0x01 in that order, followed by 0x00 in the header-check slot (byte 4), which is left for downstream check insertion.
- R3: Bytes 5 through 52 of an idle cell are all 0x6A.
- R4: When `drop_fill_en` is 1 during the last byte of an incoming cell, a cell whose first 31 header bits are zero is discarded: this covers idle (0x00000001) and unassigned (0x00000000, any CLP). When `drop_fill_en` is 0, such a cell is buffered like any other.
- R5: While `link_en` is 0, only idle cells are sent, and buffered cells stay in the buffer.
- R6: The usable depth is `depth_cfg` cells, clamped to the build capacity `MAX_CELLS`, which itself is limited to 58.
- R7: Once the first byte of a cell has been sent, the remaining 52 bytes of that same cell follow, even if `link_en` changes part-way through.
- R8: An incoming cell whose first byte arrives while the fill level is at or above the usable depth is dropped whole, and `overflow` goes to 1 and stays there until reset.
- R9: `fill_cells` counts complete buffered cells only: a cell that is still arriving is not counted until its last byte has been accepted.
- R10: Each `out_req` high in a cycle yields exactly one output byte, with `out_valid` high in the next cycle, and `out_sop` marks byte 0 of each cell.
- R11: After reset, `out_valid`, `fill_cells` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is byte 0 of a cell |
| in_byte | input | 8 | Input cell byte |
| link_en | input | 1 | Allows user cells onto the link |
| drop_fill_en | input | 1 | Discard idle/unassigned cells on input |
| depth_cfg | input | CNT_W | Usable buffer depth in cells |
| out_req | input | 1 | Downstream requests one byte |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output byte is byte 0 of a cell |
| out_byte | output | 8 | Output cell byte |
| fill_cells | output | CNT_W | Complete cells buffered |
| overflow | output | 1 | Sticky: a cell was lost to a full buffer |

## Verification
The output side is tried under two request patterns: a steady stream, and an irregular pseudo-random strobe. This separates byte-per-request pacing from cell ordering. The input side sends distinct user cells, idle-pattern cells and unassigned cells, each with the removal option both on and off, so the filter is shown to act only on the header match and only when enabled. The buffer is loaded while the link is disabled, which holds its contents still: the fill level, the depth clamp and the overflow drop can then be read exactly. The link enable is then toggled part-way through a user cell to show that cells are never cut.

// File: rtl/atm_tx_pkg.sv
// Shared constants and helpers for the transmit cell scheduler.
package atm_tx_pkg;
    localparam int CELL_BYTES = 53;
    localparam int IDX_W      = 6;
    localparam int CAP_LIMIT  = 58;
    localparam logic [7:0] IDLE_FILL = 8'h6A;

    // Byte of the idle cell at position idx (header, check slot, payload).
    function automatic logic [7:0] idle_byte(input logic [IDX_W-1:0] idx);
        if (idx == IDX_W'(3))      return 8'h01;
        else if (idx < IDX_W'(5))  return 8'h00;
        else                       return IDLE_FILL;
    endfunction

    // True for idle or unassigned headers (CLP bit ignored).
    function automatic logic hdr_is_filler(input logic [31:0] hdr);
        return (hdr[31:1] == 31'd0);
    endfunction
endpackage

// File: rtl/atm_cell_capture.sv
// Input cell capture: tracks byte position of arriving cells, writes bytes
// into the free buffer slot and decides at the last byte whether to commit.
// Assumes the 53 bytes of a cell arrive with in_sop on byte 0; a new in_sop
// abandons any partial cell. The full decision is taken at byte 0.
module atm_cell_capture
    import atm_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_byte,
    input  logic             drop_en,
    input  logic             store_full,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             commit,
    output logic             ovf_drop
);
    logic             active_q;
    logic             block_q;
    logic [IDX_W-1:0] idx_q;
    logic [31:0]      hdr_q;

    logic             take;
    logic             last;
    logic             cur_block;
    logic [IDX_W-1:0] cur_idx;

    // Current byte position, block state and commit decision.
    always_comb begin
        take      = in_valid && (in_sop || active_q);
        cur_idx   = in_sop ? '0 : idx_q;
        cur_block = in_sop ? store_full : block_q;
        last      = take && (cur_idx == IDX_W'(CELL_BYTES-1));
        wr_en     = take && !cur_block;
        wr_idx    = cur_idx;
        wr_data   = in_byte;
        commit    = last && !cur_block && !(drop_en && hdr_is_filler(hdr_q));
        ovf_drop  = last && cur_block;
    end

    // Advance the byte position and gather the four header bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            block_q  <= 1'b0;
            idx_q    <= '0;
            hdr_q    <= '0;
        end else if (take) begin
            active_q <= !last;
            block_q  <= cur_block;
            idx_q    <= last ? '0 : cur_idx + IDX_W'(1);
            if (cur_idx < IDX_W'(4))
                hdr_q <= {hdr_q[23:0], in_byte};
        end
    end
endmodule

// File: rtl/atm_cell_store.sv
// Cell buffer: SLOTS cell-sized slots used as a ring. Bytes are written in
// place into the slot after the newest committed cell; a commit publishes
// it. Reads are combinational from the oldest slot at the requested index.
module atm_cell_store
    import atm_tx_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             commit,
    input  logic [CNT_W-1:0] depth_cfg,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             pop,
    output logic [7:0]       rd_data,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int DEPTH  = SLOTS * CELL_BYTES;
    localparam int ADDR_W = $clog2(DEPTH);

    logic [7:0]        mem [DEPTH];
    logic [SLOT_W-1:0] wr_slot, rd_slot;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [CNT_W-1:0]  depth_eff;

    // Byte addresses and clamped depth.
    always_comb begin
        wr_addr   = ADDR_W'(wr_slot) * ADDR_W'(CELL_BYTES) + ADDR_W'(wr_idx);
        rd_addr   = ADDR_W'(rd_slot) * ADDR_W'(CELL_BYTES) + ADDR_W'(rd_idx);
        depth_eff = (depth_cfg > CNT_W'(SLOTS)) ? CNT_W'(SLOTS) : depth_cfg;
        full      = (count >= depth_eff);
        rd_data   = mem[rd_addr];
    end

    // Byte storage write port.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    // Ring pointers and committed-cell count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_slot <= '0;
            rd_slot <= '0;
            count   <= '0;
        end else begin
            if (commit)
                wr_slot <= (wr_slot == SLOT_W'(SLOTS-1)) ? '0 : wr_slot + SLOT_W'(1);
            if (pop)
                rd_slot <= (rd_slot == SLOT_W'(SLOTS-1)) ? '0 : rd_slot + SLOT_W'(1);
            count <= count + CNT_W'(commit) - CNT_W'(pop);
        end
    end

    // R6
    fill_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(SLOTS));
    // R1
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
    // R8
    commit_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (count < CNT_W'(SLOTS)));
endmodule

// File: rtl/atm_tx_seq.sv
// Output sequencer: emits one byte per request, choosing user or idle only
// at byte 0 and holding that choice for all 53 bytes. Releases the buffer
// slot on the last byte of a user cell. Output is registered.
module atm_tx_seq
    import atm_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_req,
    input  logic             link_en,
    input  logic             cell_ready,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             pop,
    output logic             out_valid,
    output logic             out_sop,
    output logic [7:0]       out_byte
);
    logic [IDX_W-1:0] idx_q;
    logic             user_q;
    logic             at_start;
    logic             at_end;
    logic             user_now;

    // Boundary decision and slot release.
    always_comb begin
        at_start = (idx_q == '0);
        at_end   = (idx_q == IDX_W'(CELL_BYTES-1));
        user_now = at_start ? (link_en && cell_ready) : user_q;
        rd_idx   = idx_q;
        pop      = out_req && at_end && user_q;
    end

    // Byte emission and position tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            user_q    <= 1'b0;
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= out_req;
            if (out_req) begin
                out_byte <= user_now ? rd_data : idle_byte(idx_q);
                out_sop  <= at_start;
                user_q   <= user_now;
                idx_q    <= at_end ? '0 : idx_q + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/atm_tx_cell_sched.sv
// Top: one-link transmit cell scheduler with idle fill. Connects input
// capture, cell buffer and output sequencer; holds the sticky overflow flag.
// MAX_CELLS above the 58-cell limit is clamped.
module atm_tx_cell_sched
    import atm_tx_pkg::*;
#(
    parameter  int MAX_CELLS = 8,
    localparam int SLOTS     = (MAX_CELLS > CAP_LIMIT) ? CAP_LIMIT : MAX_CELLS,
    localparam int CNT_W     = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_byte,
    input  logic             link_en,
    input  logic             drop_fill_en,
    input  logic [CNT_W-1:0] depth_cfg,
    input  logic             out_req,
    output logic             out_valid,
    output logic             out_sop,
    output logic [7:0]       out_byte,
    output logic [CNT_W-1:0] fill_cells,
    output logic             overflow
);
    logic             wr_en, commit, ovf_drop, store_full, pop;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;

    atm_cell_capture u_capture (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_byte(in_byte), .drop_en(drop_fill_en), .store_full(store_full),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .commit(commit), .ovf_drop(ovf_drop)
    );

    atm_cell_store #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .commit(commit), .depth_cfg(depth_cfg),
        .rd_idx(rd_idx), .pop(pop), .rd_data(rd_data),
        .count(fill_cells), .full(store_full)
    );

    atm_tx_seq u_seq (
        .clk(clk), .rst_n(rst_n), .out_req(out_req), .link_en(link_en),
        .cell_ready(fill_cells != '0), .rd_data(rd_data), .rd_idx(rd_idx),
        .pop(pop), .out_valid(out_valid), .out_sop(out_sop), .out_byte(out_byte)
    );

    // Sticky record of cells lost to a full buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)        overflow <= 1'b0;
        else if (ovf_drop) overflow <= 1'b1;
    end

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: tb/atm_tx_cell_sched_bench.sv
`timescale 1ns/1ps
module atm_tx_cell_sched_bench;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0;
    logic [7:0] in_byte = '0;
    logic link_en = 1'b0, drop_fill_en = 1'b0;
    logic [CNT_W-1:0] depth_cfg = 4'd8;
    logic out_req;
    logic out_valid, out_sop;
    logic [7:0] out_byte;
    logic [CNT_W-1:0] fill_cells;
    logic overflow;

    always #2.5 clk = ~clk;

    atm_tx_cell_sched u_atm_tx_cell_sched (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_byte(in_byte), .link_en(link_en), .drop_fill_en(drop_fill_en),
        .depth_cfg(depth_cfg), .out_req(out_req), .out_valid(out_valid),
        .out_sop(out_sop), .out_byte(out_byte), .fill_cells(fill_cells),
        .overflow(overflow)
    );

    int n_checks = 0, n_fail = 0;
    int user_cnt = 0, idle_cnt = 0;
    bit user_started = 0;
    bit pace = 0;
    logic [423:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [423:0] make_cell(input logic [31:0] hdr, input logic [7:0] seed);
        logic [423:0] c;
        for (int i = 0; i < 4; i++) c[i*8 +: 8] = hdr[31-8*i -: 8];
        c[32 +: 8] = 8'hC5 ^ seed;
        for (int i = 5; i < 53; i++) c[i*8 +: 8] = seed + 8'(i);
        return c;
    endfunction

    // Driver: pushes expected cell, then drives its 53 bytes.
    task automatic send_cell(input logic [423:0] c, input bit keep, input bit chk_partial);
        int start;
        start = int'(fill_cells);
        if (keep) exp_q.push_back(c);
        for (int i = 0; i < 53; i++) begin
            @(negedge clk);
            if (chk_partial && i == 52)
                chk(int'(fill_cells) == start, "R9", "fill during partial cell", fill_cells, start);
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_byte  = c[i*8 +: 8];
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
    endtask

    task automatic wait_user(input int n);
        for (int k = 0; k < 4000 && user_cnt < n; k++) @(negedge clk);
        chk(user_cnt >= n, "R1", "user cells delivered", user_cnt, n);
    endtask

    // Monitor: drives the request strobe, assembles cells, compares.
    initial begin : monitor
        logic [423:0] cur;
        logic [423:0] e;
        int m_idx;
        bit prev_req;
        bit ok;
        logic [15:0] lfsr;
        cur = '0; m_idx = 0; prev_req = 0; lfsr = 16'hACE1;
        out_req = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                chk(out_valid == prev_req, "R10", "out_valid follows out_req", out_valid, prev_req);
                if (out_valid) begin
                    if (out_sop) begin
                        chk(m_idx == 0, "R7", "cell cut short at byte", m_idx, 0);
                        m_idx = 0;
                    end else if (m_idx == 0) begin
                        chk(0, "R10", "missing sop", 0, 1);
                    end
                    cur[m_idx*8 +: 8] = out_byte;
                    m_idx++;
                    if (m_idx == 5 && cur[31:0] != 32'h01000000) user_started = 1;
                    if (m_idx == 53) begin
                        m_idx = 0;
                        if (cur[31:0] == 32'h01000000) begin
                            idle_cnt++;
                            chk(cur[39:32] == 8'h00, "R2", "idle check slot", cur[39:32], 0);
                            ok = 1;
                            for (int i = 5; i < 53; i++) if (cur[i*8 +: 8] != 8'h6A) ok = 0;
                            chk(ok, "R3", "idle payload all 0x6A", ok, 1);
                        end else if (exp_q.size() == 0) begin
                            chk(0, "R1", "unexpected user cell hdr", cur[31:0], 0);
                        end else begin
                            e = exp_q.pop_front();
                            chk(cur == e, "R1", "user cell hdr", cur[31:0], e[31:0]);
                            user_cnt++;
                        end
                    end
                end
                if (pace) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    out_req = lfsr[0];
                end else begin
                    out_req = 1'b1;
                end
                prev_req = out_req;
            end else begin
                out_req = 1'b0;
                prev_req = 0;
            end
        end
    end

    task automatic run_all();
        int u0, i0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #0.1;
        chk(out_valid == 0, "R11", "out_valid after reset", out_valid, 0);
        chk(fill_cells == 0, "R11", "fill after reset", fill_cells, 0);
        chk(overflow == 0, "R11", "overflow after reset", overflow, 0);

        // Load while link disabled.
        send_cell(make_cell(32'h01020304, 8'h10), 1, 1);
        chk(fill_cells == 1, "R9", "fill after one cell", fill_cells, 1);
        send_cell(make_cell(32'h0A0B0C0E, 8'h40), 1, 1);
        chk(fill_cells == 2, "R9", "fill after two cells", fill_cells, 2);
        u0 = user_cnt; i0 = idle_cnt;
        repeat (200) @(negedge clk);
        chk(user_cnt == u0, "R5", "no user cells while disabled", user_cnt, u0);
        chk(idle_cnt > i0, "R5", "idle cells while disabled", idle_cnt, i0 + 1);
        chk(fill_cells == 2, "R5", "buffer held while disabled", fill_cells, 2);

        // Removal option on: idle and unassigned (CLP 0) dropped.
        drop_fill_en = 1'b1;
        send_cell(make_cell(32'h00000001, 8'h6A), 0, 0);
        chk(fill_cells == 2, "R4", "idle cell dropped", fill_cells, 2);
        send_cell(make_cell(32'h00000000, 8'h22), 0, 0);
        chk(fill_cells == 2, "R4", "unassigned cell dropped", fill_cells, 2);
        send_cell(make_cell(32'h00000010, 8'h33), 1, 0);
        chk(fill_cells == 3, "R4", "non-filler header kept", fill_cells, 3);
        // Removal option off: unassigned kept.
        drop_fill_en = 1'b0;
        send_cell(make_cell(32'h00000000, 8'h11), 1, 0);
        chk(fill_cells == 4, "R4", "unassigned kept with option off", fill_cells, 4);

        // Depth limit and overflow.
        depth_cfg = 4'd4;
        send_cell(make_cell(32'h0F0F0F0E, 8'h55), 0, 0);
        chk(fill_cells == 4, "R6", "cell refused at depth 4", fill_cells, 4);
        chk(overflow == 1, "R8", "overflow set", overflow, 1);
        depth_cfg = 4'd15;
        send_cell(make_cell(32'h12345670, 8'h77), 1, 0);
        chk(fill_cells == 5, "R6", "depth above capacity clamps, room remains", fill_cells, 5);
        chk(overflow == 1, "R8", "overflow sticky", overflow, 1);

        // Drain with steady requests.
        @(negedge clk);
        link_en = 1'b1;
        wait_user(5);

        // Paced requests with traffic.
        pace = 1;
        send_cell(make_cell(32'h20304050, 8'h90), 1, 0);
        send_cell(make_cell(32'h60708090, 8'hA0), 1, 0);
        wait_user(7);
        pace = 0;

        // Disable mid-cell: cell must complete.
        repeat (60) @(negedge clk);
        user_started = 0;
        send_cell(make_cell(32'hCAFE0000, 8'hB0), 1, 0);
        for (int k = 0; k < 400 && !user_started; k++) @(negedge clk);
        chk(user_started, "R7", "user cell started", user_started, 1);
        repeat (10) @(negedge clk);
        link_en = 1'b0;
        wait_user(8);
        chk(fill_cells == 0, "R9", "fill after drain", fill_cells, 0);

        // Empty buffer with link enabled: idle fill.
        link_en = 1'b1;
        i0 = idle_cnt;
        repeat (150) @(negedge clk);
        chk(idle_cnt >= i0 + 2, "R1", "idle when empty", idle_cnt, i0 + 2);
        chk(exp_q.size() == 0, "R1", "all expected cells seen", exp_q.size(), 0);
    endtask

    initial begin
        bit timed_out;
        timed_out = 0;
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) chk(0, "R1", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule